// File: doc/BRIEF.md
# Power Register Access Command Engine

This block is the service side of a mailbox used to reach power-control registers. A requester fills an outbound byte buffer and posts a command: a message code, a sub-command and a payload size. The engine accepts only the power-register message code. It decodes the sub-command as a write, a read or a read-modify-write, and walks the payload one byte per cycle. It applies byte accesses to an internal register file of 8-bit entries, places any read results in the inbound byte buffer, and ends with a one-cycle completion pulse that carries an error flag and an error code.

The payload starts with a list of 16-bit register addresses. Each is stored low byte first in a pair of consecutive buffer bytes. The register file is indexed by the low bits of each address. A write list is followed by one data byte per address. A read-modify-write carries one address, a value byte and a mask byte. A malformed command changes nothing and only reports an error.

Top module: `pwr_cmd_engine`

## Requirements
- R1: After reset, `done` and `busy` are low and every register entry reads as 0x00.
- R2: A start whose message code is not 0xFF is ignored: `busy` stays low, no `done` follows and no inbound byte is written.
- R3: Sub-command 0 (write) with size 3N writes N registers. Address k sits at outbound bytes 2k (low) and 2k+1 (high). Data byte k sits at outbound byte 2N+k. The register index is the low 8 bits of the address, so the high byte is ignored.
- R4: Sub-command 1 (read) with size 2N reads N registers. The value of address k is written to inbound byte k, and inbound bytes N through 15 are written as 0x00.
- R5: Sub-command 2 (read-modify-write) with size 4 takes its address from outbound bytes 0 and 1, a value from byte 2 and a mask from byte 3. The register becomes (old AND NOT mask) OR (value AND mask).
- R6: Accesses run in list order. A write list that names the same register twice leaves the last data byte.
- R7: An unknown sub-command (above 2) gives error code 0x01, a count N of 0 or above 5 gives code 0x02, and a size that does not fit the sub-command's rule gives code 0x03. In every such case `done` rises with `err_flag` high, and neither a register nor an inbound byte is changed.
- R8: `done` is high for exactly one cycle per accepted command. `busy` is high from the cycle after acceptance through the `done` cycle. On success `err_flag` is 0 and `err_code` is 0x00.
- R9: A start presented while `busy` is high is ignored; it neither produces a second `done` nor touches any register.
- R10: A command that names 5 registers (the largest count) completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Command strobe, one cycle |
| startMsg | input | 8 | Message code; only 0xFF is served |
| startSub | input | 4 | Sub-command: 0 write, 1 read, 2 read-modify-write |
| startSize | input | 8 | Payload size in bytes |
| obRdAddr | output | 4 | Outbound buffer byte address |
| obRdData | input | 8 | Outbound buffer byte at obRdAddr, same cycle |
| ibWrEn | output | 1 | Inbound buffer byte write enable |
| ibWrAddr | output | 4 | Inbound buffer byte address |
| ibWrData | output | 8 | Inbound buffer byte data |
| busy | output | 1 | Engine is running a command |
| done | output | 1 | One-cycle completion pulse |
| errFlag | output | 1 | Command failed; valid with done, held until the next acceptance |
| errCode | output | 8 | 0x00 success, 0x01 sub-command, 0x02 count, 0x03 size |

## Verification
Register file state is visible only through later read commands. A corrupted entry, a wrong index taken from the address high byte, or a mis-ordered duplicate write therefore shows up in the inbound bytes of the next read, one command later. A wrong byte-pointer or item counter shows up within the same command as wrong inbound addresses, a missing zero fill, or a `done` pulse that comes early, late or twice. Error decoding is seen directly at `done`, and a read afterwards confirms that the rejected command left the registers untouched.

// File: rtl/pwr_cmd_pkg.sv
package pwr_cmd_pkg;

  typedef enum logic [3:0] {
    SUB_WRITE = 4'd0,
    SUB_READ  = 4'd1,
    SUB_RMW   = 4'd2
  } subOp_e;

  // Which outbound byte the datapath presents this cycle
  typedef enum logic [1:0] {
    OB_ADDR = 2'd0,   // low address byte of current item
    OB_DATA = 2'd1,   // write data byte of current item
    OB_VAL  = 2'd2,   // rmw value byte
    OB_MASK = 2'd3    // rmw mask byte
  } obSel_e;

  typedef struct packed {
    logic   clrIdx;
    logic   incIdx;
    logic   loadCnt;
    logic   latchAddr;
    logic   latchVal;
    logic   rfWrite;
    logic   rfRmw;
    logic   ibRead;
    logic   ibZero;
    obSel_e obSel;
  } ctrlStrobe_t;

  localparam logic [7:0] ERR_NONE  = 8'h00;
  localparam logic [7:0] ERR_SUB   = 8'h01;
  localparam logic [7:0] ERR_COUNT = 8'h02;
  localparam logic [7:0] ERR_SIZE  = 8'h03;

endpackage

// File: rtl/pwr_cmd_datapath.sv
module pwr_cmd_datapath
  import pwr_cmd_pkg::*;
#(
  parameter int OB_BYTES  = 16,
  parameter int IB_BYTES  = 16,
  parameter int RF_DEPTH  = 256,
  parameter int MAX_ITEMS = 5,
  localparam int OB_AW = $clog2(OB_BYTES),
  localparam int IB_AW = $clog2(IB_BYTES),
  localparam int RF_AW = $clog2(RF_DEPTH),
  localparam int CNT_W = $clog2(MAX_ITEMS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [CNT_W-1:0] loadN,
  output logic [OB_AW-1:0] obRdAddr,
  input  logic [7:0]       obRdData,
  output logic             ibWrEn,
  output logic [IB_AW-1:0] ibWrAddr,
  output logic [7:0]       ibWrData,
  output logic             lastItem,
  output logic             lastFill
);

  logic [CNT_W-1:0] itemCnt;
  logic [IB_AW-1:0] idx;
  logic [RF_AW-1:0] regIdx;
  logic [7:0]       valByte;
  logic [7:0]       rfQ [RF_DEPTH];
  logic [7:0]       rfRd;
  logic [7:0]       rfNext;
  logic             rfWe;

  // Item count and running byte index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      itemCnt <= '0;
      idx     <= '0;
    end else begin
      if (strobe.loadCnt) itemCnt <= loadN;
      if (strobe.clrIdx)      idx <= '0;
      else if (strobe.incIdx) idx <= idx + IB_AW'(1);
    end
  end

  // Address and value latches
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regIdx  <= '0;
      valByte <= '0;
    end else begin
      if (strobe.latchAddr) regIdx  <= obRdData[RF_AW-1:0];
      if (strobe.latchVal)  valByte <= obRdData;
    end
  end

  assign lastItem = ((idx + IB_AW'(1)) == IB_AW'(itemCnt));
  assign lastFill = (idx == IB_AW'(IB_BYTES - 1));

  // Outbound byte pointer
  always_comb begin
    case (strobe.obSel)
      OB_ADDR: obRdAddr = OB_AW'({idx, 1'b0});
      OB_DATA: obRdAddr = OB_AW'({itemCnt, 1'b0}) + OB_AW'(idx);
      OB_VAL:  obRdAddr = OB_AW'(2);
      OB_MASK: obRdAddr = OB_AW'(3);
      default: obRdAddr = '0;
    endcase
  end

  // Register file: read port and merged write value
  assign rfRd   = rfQ[regIdx];
  assign rfWe   = strobe.rfWrite | strobe.rfRmw;
  assign rfNext = strobe.rfRmw ? ((rfRd & ~obRdData) | (valByte & obRdData))
                               : obRdData;

  for (genvar e = 0; e < RF_DEPTH; e++) begin : g_rf
    always_ff @(posedge clk) begin
      if (!rstN)                                 rfQ[e] <= '0;
      else if (rfWe && (regIdx == RF_AW'(e)))    rfQ[e] <= rfNext;
    end
  end

  // Inbound byte port
  assign ibWrEn   = strobe.ibRead | strobe.ibZero;
  assign ibWrAddr = idx;
  assign ibWrData = strobe.ibRead ? rfRd : 8'h00;

endmodule

// File: rtl/pwr_cmd_ctrl.sv
module pwr_cmd_ctrl
  import pwr_cmd_pkg::*;
#(
  parameter int         MAX_ITEMS = 5,
  parameter logic [7:0] MSG_CODE  = 8'hFF,
  localparam int CNT_W = $clog2(MAX_ITEMS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [7:0]       startMsg,
  input  logic [3:0]       startSub,
  input  logic [7:0]       startSize,
  input  logic             lastItem,
  input  logic             lastFill,
  output ctrlStrobe_t      strobe,
  output logic [CNT_W-1:0] loadN,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output logic [7:0]       errCode
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_DATA, ST_MASK, ST_FILL, ST_FIN
  } state_e;

  state_e     state, stateNext;
  logic [3:0] subReg;
  logic [7:0] chkCode;
  logic [7:0] sizeN;
  logic       accept;

  assign accept = (state == ST_IDLE) && startValid && (startMsg == MSG_CODE);

  // Command validation on the start strobe
  always_comb begin
    chkCode = ERR_NONE;
    sizeN   = '0;
    case (startSub)
      SUB_WRITE: begin
        if ((startSize % 8'd3) != 8'd0) chkCode = ERR_SIZE;
        else                            sizeN   = startSize / 8'd3;
      end
      SUB_READ: begin
        if (startSize[0]) chkCode = ERR_SIZE;
        else              sizeN   = {1'b0, startSize[7:1]};
      end
      SUB_RMW: begin
        if (startSize != 8'd4) chkCode = ERR_SIZE;
        else                   sizeN   = 8'd1;
      end
      default: chkCode = ERR_SUB;
    endcase
    if ((chkCode == ERR_NONE) && ((sizeN == 8'd0) || (sizeN > 8'(MAX_ITEMS))))
      chkCode = ERR_COUNT;
  end

  assign loadN = CNT_W'(sizeN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      subReg  <= '0;
      errFlag <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      state <= stateNext;
      if (accept) begin
        subReg  <= startSub;
        errFlag <= (chkCode != ERR_NONE);
        errCode <= chkCode;
      end
    end
  end

  // Sequencing and strobes
  always_comb begin
    strobe    = '0;
    strobe.obSel = OB_ADDR;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (accept) begin
          strobe.loadCnt = 1'b1;
          strobe.clrIdx  = 1'b1;
          stateNext = (chkCode != ERR_NONE) ? ST_FIN : ST_ADDR;
        end
      end
      ST_ADDR: begin
        strobe.obSel     = OB_ADDR;
        strobe.latchAddr = 1'b1;
        stateNext = ST_DATA;
      end
      ST_DATA: begin
        case (subReg)
          SUB_WRITE: begin
            strobe.obSel   = OB_DATA;
            strobe.rfWrite = 1'b1;
            if (lastItem) stateNext = ST_FIN;
            else begin
              strobe.incIdx = 1'b1;
              stateNext = ST_ADDR;
            end
          end
          SUB_READ: begin
            strobe.ibRead = 1'b1;
            strobe.incIdx = 1'b1;
            stateNext = lastItem ? ST_FILL : ST_ADDR;
          end
          default: begin
            strobe.obSel    = OB_VAL;
            strobe.latchVal = 1'b1;
            stateNext = ST_MASK;
          end
        endcase
      end
      ST_MASK: begin
        strobe.obSel = OB_MASK;
        strobe.rfRmw = 1'b1;
        stateNext = ST_FIN;
      end
      ST_FILL: begin
        strobe.ibZero = 1'b1;
        strobe.incIdx = 1'b1;
        if (lastFill) stateNext = ST_FIN;
      end
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_FIN);

endmodule

// File: rtl/pwr_cmd_engine.sv
module pwr_cmd_engine
  import pwr_cmd_pkg::*;
#(
  parameter int         OB_BYTES  = 16,
  parameter int         IB_BYTES  = 16,
  parameter int         RF_DEPTH  = 256,
  parameter int         MAX_ITEMS = 5,
  parameter logic [7:0] MSG_CODE  = 8'hFF,
  localparam int OB_AW = $clog2(OB_BYTES),
  localparam int IB_AW = $clog2(IB_BYTES),
  localparam int CNT_W = $clog2(MAX_ITEMS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startValid,
  input  logic [7:0]       startMsg,
  input  logic [3:0]       startSub,
  input  logic [7:0]       startSize,
  output logic [OB_AW-1:0] obRdAddr,
  input  logic [7:0]       obRdData,
  output logic             ibWrEn,
  output logic [IB_AW-1:0] ibWrAddr,
  output logic [7:0]       ibWrData,
  output logic             busy,
  output logic             done,
  output logic             errFlag,
  output logic [7:0]       errCode
);

  ctrlStrobe_t      strobe;
  logic [CNT_W-1:0] loadN;
  logic             lastItem;
  logic             lastFill;

  pwr_cmd_ctrl #(
    .MAX_ITEMS (MAX_ITEMS),
    .MSG_CODE  (MSG_CODE)
  ) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .startMsg   (startMsg),
    .startSub   (startSub),
    .startSize  (startSize),
    .lastItem   (lastItem),
    .lastFill   (lastFill),
    .strobe     (strobe),
    .loadN      (loadN),
    .busy       (busy),
    .done       (done),
    .errFlag    (errFlag),
    .errCode    (errCode)
  );

  pwr_cmd_datapath #(
    .OB_BYTES  (OB_BYTES),
    .IB_BYTES  (IB_BYTES),
    .RF_DEPTH  (RF_DEPTH),
    .MAX_ITEMS (MAX_ITEMS)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .loadN    (loadN),
    .obRdAddr (obRdAddr),
    .obRdData (obRdData),
    .ibWrEn   (ibWrEn),
    .ibWrAddr (ibWrAddr),
    .ibWrData (ibWrData),
    .lastItem (lastItem),
    .lastFill (lastFill)
  );

endmodule

// File: rtl/pwr_cmd_engine_chk.sv
module pwr_cmd_engine_chk #(
  parameter logic [7:0] MSG_CODE = 8'hFF
) (
  input logic       clk,
  input logic       rstN,
  input logic       startValid,
  input logic [7:0] startMsg,
  input logic       ibWrEn,
  input logic       busy,
  input logic       done,
  input logic       errFlag,
  input logic [7:0] errCode
);

  // R8: completion pulse lasts one cycle
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: done lies inside the busy window and ends it
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);
  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  // R8: success reports code zero
  a_r8_ok_code: assert property (@(posedge clk) disable iff (!rstN)
    (done && !errFlag) |-> (errCode == 8'h00));

  // R7: a failure always carries a nonzero code
  a_r7_err_code: assert property (@(posedge clk) disable iff (!rstN)
    (done && errFlag) |-> (errCode != 8'h00));

  // R9: busy only begins from a served start strobe
  a_r9_busy_from_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startValid && (startMsg == MSG_CODE)));

  // R2: a foreign message code leaves the engine idle
  a_r2_foreign_msg: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && (startMsg != MSG_CODE)) |=> !busy);

  // R4: inbound writes happen only during a command
  a_r4_ib_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    ibWrEn |-> busy);

endmodule

bind pwr_cmd_engine pwr_cmd_engine_chk #(.MSG_CODE(MSG_CODE)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .startValid (startValid),
  .startMsg   (startMsg),
  .ibWrEn     (ibWrEn),
  .busy       (busy),
  .done       (done),
  .errFlag    (errFlag),
  .errCode    (errCode)
);

// File: tb/pwr_cmd_engine_tb_top.sv
module pwr_cmd_engine_tb_top;

  logic       clk = 1'b0;
  logic       rstN;
  logic       startValid;
  logic [7:0] startMsg;
  logic [3:0] startSub;
  logic [7:0] startSize;
  logic [3:0] obRdAddr;
  logic [7:0] obRdData;
  logic       ibWrEn;
  logic [3:0] ibWrAddr;
  logic [7:0] ibWrData;
  logic       busy, done, errFlag;
  logic [7:0] errCode;

  logic [7:0] obBuf [16];
  logic [7:0] ibBuf [16];
  logic [7:0] rfModel [256];
  int nChecks = 0;
  int nErrors = 0;
  int ibWrCnt = 0;
  int doneCnt = 0;
  int cycles  = 0;
  logic       gotErr;
  logic [7:0] gotCode;

  always #2 clk = ~clk;

  pwr_cmd_engine dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startMsg(startMsg),
    .startSub(startSub), .startSize(startSize), .obRdAddr(obRdAddr),
    .obRdData(obRdData), .ibWrEn(ibWrEn), .ibWrAddr(ibWrAddr),
    .ibWrData(ibWrData), .busy(busy), .done(done), .errFlag(errFlag),
    .errCode(errCode)
  );

  assign obRdData = obBuf[obRdAddr];

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (ibWrEn) begin
      ibBuf[ibWrAddr] <= ibWrData;
      ibWrCnt <= ibWrCnt + 1;
    end
    if (done) doneCnt <= doneCnt + 1;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearOb();
    for (int i = 0; i < 16; i++) obBuf[i] = 8'h00;
  endtask

  // Post one command and wait for its completion pulse
  task automatic issue(input logic [7:0] msg, input logic [3:0] sub,
                       input logic [7:0] size);
    int t = 0;
    @(negedge clk);
    startValid = 1'b1; startMsg = msg; startSub = sub; startSize = size;
    @(negedge clk);
    startValid = 1'b0;
    check(busy == 1'b1, "R8 busy after accept", busy, 1);
    while (!done && t < 200) begin @(negedge clk); t++; end
    check(t < 200, "R8 done arrives", t, 0);
    gotErr = errFlag; gotCode = errCode;
    @(negedge clk);
    check(done == 1'b0, "R8 done single cycle", done, 0);
    check(busy == 1'b0, "R8 idle after done", busy, 0);
  endtask

  task automatic writeRegs(input logic [15:0] a [8], input logic [7:0] d [8],
                           input int n, input string req);
    clearOb();
    for (int k = 0; k < n; k++) begin
      obBuf[2*k] = a[k][7:0]; obBuf[2*k+1] = a[k][15:8];
      obBuf[2*n+k] = d[k];
      rfModel[a[k][7:0]] = d[k];
    end
    issue(8'hFF, 4'd0, 8'(3*n));
    check(gotErr == 1'b0 && gotCode == 8'h00, req, {gotErr, gotCode}, 0);
  endtask

  task automatic readCheck(input logic [15:0] a [8], input int n,
                           input string req);
    int w0;
    clearOb();
    for (int i = 0; i < 16; i++) ibBuf[i] = 8'hEE;
    for (int k = 0; k < n; k++) begin
      obBuf[2*k] = a[k][7:0]; obBuf[2*k+1] = a[k][15:8];
    end
    w0 = ibWrCnt;
    issue(8'hFF, 4'd1, 8'(2*n));
    check(gotErr == 1'b0 && gotCode == 8'h00, "R8 read ok status",
          {gotErr, gotCode}, 0);
    check(ibWrCnt - w0 == 16, "R4 inbound bytes written", ibWrCnt - w0, 16);
    for (int k = 0; k < n; k++)
      check(ibBuf[k] == rfModel[a[k][7:0]], req, ibBuf[k], rfModel[a[k][7:0]]);
    for (int k = n; k < 16; k++)
      check(ibBuf[k] == 8'h00, "R4 zero fill", ibBuf[k], 0);
  endtask

  task automatic t_reset();
    logic [15:0] a [8] = '{16'h0000, 16'h007F, 16'h00FF, 16'h0080, 16'h0001,
                           0, 0, 0};
    check(done == 1'b0 && busy == 1'b0, "R1 reset outputs", {done, busy}, 0);
    readCheck(a, 5, "R1 reset register value");
  endtask

  task automatic t_foreignMsg();
    int w0 = ibWrCnt, d0 = doneCnt;
    @(negedge clk);
    startValid = 1'b1; startMsg = 8'hFE; startSub = 4'd1; startSize = 8'd2;
    @(negedge clk);
    startValid = 1'b0;
    check(busy == 1'b0, "R2 busy stays low", busy, 0);
    repeat (30) @(negedge clk);
    check(doneCnt == d0, "R2 no done", doneCnt - d0, 0);
    check(ibWrCnt == w0, "R2 no inbound write", ibWrCnt - w0, 0);
  endtask

  task automatic t_writeRead();
    logic [15:0] a [8] = '{16'h0010, 16'h1234, 16'hFF00, 0, 0, 0, 0, 0};
    logic [7:0]  d [8] = '{8'hA1, 8'hB2, 8'hC3, 0, 0, 0, 0, 0};
    logic [15:0] r [8] = '{16'h0034, 16'h0000, 16'h0010, 0, 0, 0, 0, 0};
    writeRegs(a, d, 3, "R3 write status");
    readCheck(r, 3, "R3 high address byte ignored");
    readCheck(a, 1, "R4 single read");
  endtask

  task automatic t_max();
    logic [15:0] a [8] = '{16'h00F0, 16'h00F1, 16'h00F2, 16'h00F3, 16'h00F4,
                           0, 0, 0};
    logic [7:0]  d [8] = '{8'h01, 8'h23, 8'h45, 8'h67, 8'h89, 0, 0, 0};
    writeRegs(a, d, 5, "R10 five-register write");
    readCheck(a, 5, "R10 five-register read");
  endtask

  task automatic t_dup();
    logic [15:0] a [8] = '{16'h0020, 16'h0120, 16'h0021, 0, 0, 0, 0, 0};
    logic [7:0]  d [8] = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
    writeRegs(a, d, 3, "R6 duplicate write status");
    check(rfModel[8'h20] == 8'h22, "R6 model last wins", rfModel[8'h20], 8'h22);
    readCheck(a, 3, "R6 last write wins");
  endtask

  task automatic t_rmw();
    logic [15:0] a [8] = '{16'h0040, 0, 0, 0, 0, 0, 0, 0};
    logic [7:0]  d [8] = '{8'hA5, 0, 0, 0, 0, 0, 0, 0};
    writeRegs(a, d, 1, "R5 preset");
    clearOb();
    obBuf[0] = 8'h40; obBuf[1] = 8'h9C; obBuf[2] = 8'h0F; obBuf[3] = 8'h3C;
    issue(8'hFF, 4'd2, 8'd4);
    check(gotErr == 1'b0, "R5 rmw status", gotErr, 0);
    rfModel[8'h40] = 8'h8D;  // (A5 & ~3C) | (0F & 3C)
    readCheck(a, 1, "R5 masked update");
  endtask

  task automatic expectErr(input logic [3:0] sub, input logic [7:0] size,
                           input logic [7:0] code, input string req);
    int w0;
    logic [15:0] a [8] = '{16'h0020, 16'h0040, 0, 0, 0, 0, 0, 0};
    clearOb();
    obBuf[0] = 8'h20; obBuf[2] = 8'h40; obBuf[3] = 8'hFF;
    for (int i = 4; i < 16; i++) obBuf[i] = 8'h99;
    w0 = ibWrCnt;
    issue(8'hFF, sub, size);
    check(gotErr == 1'b1, req, gotErr, 1);
    check(gotCode == code, req, gotCode, code);
    check(ibWrCnt == w0, "R7 no inbound write on error", ibWrCnt - w0, 0);
    readCheck(a, 2, "R7 registers unchanged");
  endtask

  task automatic t_errors();
    expectErr(4'd3, 8'd3,  8'h01, "R7 unknown sub");
    expectErr(4'd0, 8'd4,  8'h03, "R7 write size");
    expectErr(4'd0, 8'd18, 8'h02, "R7 write count six");
    expectErr(4'd1, 8'd0,  8'h02, "R7 read count zero");
    expectErr(4'd1, 8'd12, 8'h02, "R7 read count six");
    expectErr(4'd1, 8'd3,  8'h03, "R7 read odd size");
    expectErr(4'd2, 8'd3,  8'h03, "R7 rmw size");
  endtask

  task automatic t_busyIgnore();
    logic [15:0] a [8] = '{16'h0050, 16'h7751, 0, 0, 0, 0, 0, 0};
    logic [7:0]  d [8] = '{8'h3C, 8'h5A, 0, 0, 0, 0, 0, 0};
    int d0;
    writeRegs(a, d, 2, "R9 preset");
    clearOb();
    obBuf[0] = 8'h50; obBuf[1] = 8'h00; obBuf[2] = 8'h51; obBuf[3] = 8'h77;
    d0 = doneCnt;
    @(negedge clk);
    startValid = 1'b1; startMsg = 8'hFF; startSub = 4'd1; startSize = 8'd4;
    @(negedge clk);
    startSub = 4'd0; startSize = 8'd3;   // would write 0x51 to 0x50
    @(negedge clk);
    startValid = 1'b0;
    repeat (40) @(negedge clk);
    check(doneCnt - d0 == 1, "R9 single done", doneCnt - d0, 1);
    readCheck(a, 2, "R9 register untouched");
  endtask

  initial begin
    startValid = 1'b0; startMsg = '0; startSub = '0; startSize = '0;
    for (int i = 0; i < 256; i++) rfModel[i] = 8'h00;
    clearOb();
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_foreignMsg();
    t_writeRead();
    t_max();
    t_dup();
    t_rmw();
    t_errors();
    t_busyIgnore();
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    nChecks++; nErrors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule